// File: doc/BRIEF.md
# Triggered Pattern Period Sequencer

This block is the playback gate for one channel of a waveform generator. It turns a falling edge on an active-low trigger pin into a train of fixed-length pattern periods. While a period is running, the block drives an enable that lets the downstream synthesis path play. Playback starts only when the run bit is set. In delayed-burst mode a programmable start delay comes before the first period. In continuous mode that delay is skipped and the enable stays high from the first cycle to the last.

A period can never be cut short. The block may keep going into another period only while the trigger stays low, run stays set and auto-repeat stays set. Every stop request is acted on at the next period boundary, in both modes. The period length is read at the start of each period. A change written mid-period therefore shapes the following period and leaves the current one alone.

The trigger passes through a two-flop synchronizer and then an edge detector. The latency from pin to enable is fixed and counted in edges in R3 and R4.

Top module: `pattern_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pat_on_o` and `period_stb_o` are 0 and `state_o` reads idle (2'd0).
- R2: A new run begins only on a high-to-low transition of `trig_ni` that is seen while the block is idle and `run_i` is 1. A falling edge while `run_i` is 0 is discarded. Setting `run_i` later while the trigger is already low does not start a run.
- R3: In delayed-burst mode (`cont_mode_i` = 0) with start delay D, `trig_ni` is first sampled low at clock edge k. `pat_on_o` is then 1 after edge k+3+D. With D = 0 this is edge k+3, one cycle after the edge is detected at k+2.
- R4: In continuous mode (`cont_mode_i` = 1), `start_dly_i` is ignored and `pat_on_o` is 1 after edge k+3.
- R5: Each pattern period lasts max(P,1) cycles, where P is `period_i`, so a P of 0 acts as 1. `period_stb_o` is high for exactly the first cycle of every period, and only while `pat_on_o` is 1.
- R6: `period_i` is sampled only at the edge where a period begins. A change made during a period takes effect in the next period.
- R7: At the end of a period, if `trig_ni` is still low, `run_i` is 1 and `repeat_i` is 1, the next period starts in the very next cycle. No start delay is inserted and `pat_on_o` does not drop.
- R8: Raising the trigger, clearing `run_i` or clearing `repeat_i` never shortens the running period. `pat_on_o` falls only right after the last cycle of a period in which a stop condition was present at that period's end.
- R9: Falling trigger edges that occur during the start delay or during the on state are ignored. They neither restart the delay nor start a further run after the block goes idle.
- R10: `state_o` encodes idle as 2'd0, start delay as 2'd1 and playing as 2'd2. The value 2'd3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_ni | input | 1 | Active-low trigger, asynchronous to the clock |
| run_i | input | 1 | Run enable bit |
| repeat_i | input | 1 | Auto-repeat bit |
| cont_mode_i | input | 1 | 1 = continuous (no start delay), 0 = delayed burst |
| start_dly_i | input | DLY_W | Start delay in clock cycles |
| period_i | input | PER_W | Pattern period length in cycles (0 acts as 1) |
| pat_on_o | output | 1 | Pattern-on enable |
| period_stb_o | output | 1 | One-cycle strobe at the first cycle of each period |
| state_o | output | 2 | Sequencer state: 0 idle, 1 delay, 2 on |

## Verification
The bench places each stop request (trigger release, run clear, auto-repeat clear) in the middle of a period. A design that stops at once would drop the enable several cycles early, and the expected fall event would show up at the wrong cycle. Start latency is checked with zero and non-zero delays, and in continuous mode with a large delay that must be ignored. An off-by-one in the synchronizer, in the delay count or in the delay bypass shifts the rise event. Further cases cover a period value changed mid-period and a period of zero. A trigger that falls during the delay or the on state is also driven. A design that samples the period value continuously, restarts on a stray edge, or starts when run is set while the trigger is already low would produce strobes or rises the queue does not expect.

// File: rtl/pattern_sequencer.sv
module pattern_sequencer #(
  parameter int DLY_W = 16,
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_ni,
  input  logic             run_i,
  input  logic             repeat_i,
  input  logic             cont_mode_i,
  input  logic [DLY_W-1:0] start_dly_i,
  input  logic [PER_W-1:0] period_i,
  output logic             pat_on_o,
  output logic             period_stb_o,
  output logic [1:0]       state_o
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_DELAY = 2'd1, ST_ON = 2'd2} seq_state_e;

  seq_state_e       state_q;
  logic [2:0]       trig_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [PER_W-1:0] pcnt_q;
  logic             stb_q;

  wire trig_fall = trig_q[2] & ~trig_q[1];
  wire trig_low  = ~trig_q[1];
  wire keep_on   = trig_low & run_i & repeat_i;
  wire [PER_W-1:0] per_load = (period_i == '0) ? '0 : period_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 3'b111;
    end else begin
      trig_q <= {trig_q[1:0], trig_ni};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      pcnt_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trig_fall && run_i) begin
            state_q <= ST_DELAY;
            dcnt_q  <= cont_mode_i ? '0 : start_dly_i;
          end
        end
        ST_DELAY: begin
          if (dcnt_q == '0) begin
            state_q <= ST_ON;
            pcnt_q  <= per_load;
            stb_q   <= 1'b1;
          end else begin
            dcnt_q <= dcnt_q - 1'b1;
          end
        end
        ST_ON: begin
          if (pcnt_q == '0) begin
            if (keep_on) begin
              pcnt_q <= per_load;
              stb_q  <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            pcnt_q <= pcnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pat_on_o     = (state_q == ST_ON);
  assign period_stb_o = stb_q;
  assign state_o      = state_q;

  // R8
  stop_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pat_on_o) |-> ($past(pcnt_q) == '0));

  // R5
  strobe_while_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_stb_o |-> pat_on_o);

  // R3
  rise_after_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pat_on_o) |-> ($past(state_q) == ST_DELAY && $past(dcnt_q) == '0));

  // R7
  repeat_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_stb_o && $past(pat_on_o)) |-> ($past(pcnt_q) == '0 && $past(run_i) && $past(repeat_i)));

  // R2
  start_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_IDLE && state_q == ST_DELAY) |-> $past(run_i));

  // R10
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);

endmodule

// File: tb/test_pattern_sequencer.sv
module test_pattern_sequencer;
  localparam int DLY_W = 16;
  localparam int PER_W = 16;
  localparam int K_RISE = 0, K_FALL = 1, K_STB = 2;

  logic clk = 1'b0, rst_n = 1'b0, trig_n = 1'b1, run = 1'b0, rpt = 1'b0, cont = 1'b0;
  logic [DLY_W-1:0] dly = '0;
  logic [PER_W-1:0] per = 16'd8;
  logic pat_on, stb;
  logic [1:0] st;

  int cyc = 0, n_cmp = 0, n_bad = 0;
  int exp_kind[$], exp_cyc[$];
  string exp_req[$];
  logic prev_on = 1'b0;

  always #5 clk = ~clk;

  pattern_sequencer #(.DLY_W(DLY_W), .PER_W(PER_W)) i_pattern_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .trig_ni(trig_n), .run_i(run), .repeat_i(rpt),
    .cont_mode_i(cont), .start_dly_i(dly), .period_i(per),
    .pat_on_o(pat_on), .period_stb_o(stb), .state_o(st));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int c, input string req);
    exp_kind.push_back(kind); exp_cyc.push_back(c); exp_req.push_back(req);
  endtask

  task automatic take(input int kind);
    if (exp_kind.size() == 0) begin
      check(1'b0, "R9 unexpected event", kind, -1);
    end else begin
      int k = exp_kind.pop_front();
      int c = exp_cyc.pop_front();
      string r = exp_req.pop_front();
      check(k == kind, {r, " kind"}, kind, k);
      check(c == cyc, {r, " cycle"}, cyc, c);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    #2;
    if (rst_n) begin
      if (pat_on && !prev_on) take(K_RISE);
      if (!pat_on && prev_on) take(K_FALL);
      if (stb) take(K_STB);
    end
    prev_on = pat_on;
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // stop: 0 single period, 1 trigger high, 2 run clear, 3 repeat clear
  task automatic scen(input logic md, input int d, input int p, input int n,
                      input int stop, input int p_new, input string req);
    int s, t, p0, pn, c;
    p0 = (p == 0) ? 1 : p;
    pn = (p_new == 0) ? 1 : p_new;
    @(negedge clk);
    cont = md; dly = DLY_W'(d); per = PER_W'(p); run = 1'b1; rpt = (stop != 0);
    @(negedge clk);
    trig_n = 1'b0; c = cyc;
    s = c + 4 + (md ? 0 : d);
    push(K_RISE, s, req);
    t = s;
    for (int i = 0; i < n; i++) begin
      push(K_STB, t, (i == 0) ? "R5" : (i == 1 && pn != p0) ? "R6" : "R7");
      t = t + ((i == 0) ? p0 : pn);
    end
    push(K_FALL, t, (stop == 0) ? "R5" : "R8");
    if (d >= 3 && !md) begin
      wait_cyc(c + 5);
      check(st == 2'd1, "R10 delay state", st, 1);
    end
    if (pn != p0) begin
      wait_cyc(s + p0 / 2);
      per = PER_W'(p_new);
    end
    if (stop != 0) begin
      wait_cyc(t - pn + pn / 2);
      case (stop)
        1: trig_n = 1'b1;
        2: run = 1'b0;
        default: rpt = 1'b0;
      endcase
    end
    wait_cyc(t + 3);
    check(exp_kind.size() == 0, {req, " events done"}, exp_kind.size(), 0);
    check(st == 2'd0 && pat_on == 1'b0, "R8 idle after stop", st, 0);
    trig_n = 1'b1; run = 1'b1; rpt = 1'b0;
    wait_cyc(cyc + 4);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pat_on == 1'b0 && stb == 1'b0, "R1 outputs in reset", pat_on, 0);
    check(st == 2'd0, "R1 state in reset", st, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(st == 2'd0 && pat_on == 1'b0, "R1 after reset", st, 0);

    // R2: edge with run low, then run set while trigger already low
    run = 1'b0;
    @(negedge clk); trig_n = 1'b0;
    wait_cyc(cyc + 8);
    check(st == 2'd0, "R2 run low ignored", st, 0);
    run = 1'b1;
    wait_cyc(cyc + 8);
    check(st == 2'd0 && pat_on == 1'b0, "R2 late run no start", st, 0);
    trig_n = 1'b1;
    wait_cyc(cyc + 4);

    scen(1'b0, 5, 8, 1, 0, 8, "R3");
    scen(1'b0, 0, 8, 1, 0, 8, "R3 zero delay");
    scen(1'b1, 7, 10, 3, 2, 10, "R4");
    scen(1'b0, 2, 12, 2, 3, 9, "R6");
    scen(1'b0, 1, 8, 3, 1, 8, "R7");
    scen(1'b0, 2, 0, 1, 0, 0, "R5 zero period");

    // R9: falling edges during delay and during the on state are ignored
    begin
      int c, s;
      @(negedge clk);
      cont = 1'b0; dly = 16'd10; per = 16'd16; run = 1'b1; rpt = 1'b0;
      @(negedge clk);
      trig_n = 1'b0; c = cyc; s = c + 14;
      push(K_RISE, s, "R9"); push(K_STB, s, "R9"); push(K_FALL, s + 16, "R9");
      wait_cyc(c + 5); trig_n = 1'b1;
      wait_cyc(c + 9); trig_n = 1'b0;
      wait_cyc(s + 4); trig_n = 1'b1;
      wait_cyc(s + 8); trig_n = 1'b0;
      wait_cyc(s + 30);
      check(exp_kind.size() == 0, "R9 events done", exp_kind.size(), 0);
      check(st == 2'd0 && pat_on == 1'b0, "R9 no restart", st, 0);
      trig_n = 1'b1;
      wait_cyc(cyc + 4);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule